// File: doc/BRIEF.md
# Pipelined Many-Input Bitwise Reduction Tree

This block folds N operands of W bits (32 by default) into a single W-bit word. It accepts a fresh operand set on every clock and delivers one result per clock. The fold uses one associative bitwise operation, chosen at build time: AND, OR or XOR. Because the operation is associative, the operands can be grouped in any shape. The tree is built from nodes that each combine up to K operands, so a wide fan-in lets each node map onto a single wide lookup cell per bit. Every tree level is registered.

Level l has ceil(count(l-1)/K) nodes, starting from N operands at level 0. The last node of a level takes whatever operands are left over. If only one is left, that node is a plain delay register, so the leftover operand stays in step with its neighbours. The depth is the number of levels needed to bring N down to one, which is ceil(log_K N). A valid flag travels beside the data through a shift register of that depth. The registers of each level load only when the flag entering that level is set, so the output word holds its last result through idle cycles. Supported sizes include N = 9, 25, 49, 81 and 121, with K = 3, 5, 5, 6 and 6 as natural pairings. K = 2 gives a plain binary tree. N must be at least 2.

Control is a fixed pipeline with no state machine. There are two phases: the reset phase, in which every register clears, and the run phase, in which each level loads on its own valid flag.

Top module: `redtree_top`

## Requirements
- R1: With OP = AND, each valid output equals the bitwise AND of all N operands presented on the matching valid input cycle (operand i sits at in_data[i*W +: W]).
- R2: With OP = OR, each valid output equals the bitwise OR of all N operands of the matching input cycle.
- R3: With OP = XOR, each valid output equals the bitwise XOR of all N operands of the matching input cycle.
- R4: A set presented with in_valid high at clock edge e appears with out_valid high after edge e + L - 1, where L is the smallest integer with K^L >= N.
- R5: Consecutive valid input cycles give consecutive valid output cycles in the same order. A new result is produced every clock.
- R6: While rst_n (synchronous, active low) is low, and for the first L cycles after it rises, out_valid is 0. Reset sets out_data to 0.
- R7: When out_valid is 0, out_data keeps the value of the most recent result (0 after reset). Operand values on cycles with in_valid low have no effect on any output.
- R8: With K = 2 the tree is an ordinary pairwise tree. For N = 9 it has depth 4 and gives correct results, including for the unpaired ninth operand.
- R9: An operand left alone at the end of a level goes through a delay stage and still reaches the result. For example, with N = 25 and K = 6, operand 24 enters the result with the same latency as the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set on in_data is to be reduced |
| in_data | input | N*W | N operands, operand i at bits i*W +: W |
| out_valid | output | 1 | out_data carries a new result this cycle |
| out_data | output | W | Reduced result, held between results |

## Verification
Two functions can coincide in one cycle: a result leaving the last level while a new operand set enters the first, and a valid result alongside a bubble further down the pipeline. Back-to-back valid bursts cause the first case. Bursts with random gaps cause the second, so the output must update on some cycles and hold on others. The reference model shifts expected results through a queue of depth L and tracks the held value. On every clock it checks both out_valid and out_data, for three builds: XOR with K=5, OR with K=2, and AND with K=6.

// File: rtl/redtree_pkg.sv
package redtree_pkg;

    typedef enum logic [1:0] {
        RT_AND = 2'd0,
        RT_OR  = 2'd1,
        RT_XOR = 2'd2
    } rt_op_e;

    // Operand count present at the input of level lvl (level 0 = raw operands).
    function automatic int rt_count(input int n, input int k, input int lvl);
        int c;
        c = n;
        for (int i = 0; i < lvl; i++) begin
            c = (c + k - 1) / k;
        end
        return c;
    endfunction

    // Number of registered levels needed to reach one operand.
    function automatic int rt_levels(input int n, input int k);
        int c;
        int l;
        c = n;
        l = 0;
        for (int i = 0; i < 64; i++) begin
            if (c > 1) begin
                c = (c + k - 1) / k;
                l = l + 1;
            end
        end
        return l;
    endfunction

endpackage

// File: rtl/redtree_node.sv
module redtree_node
    import redtree_pkg::*;
#(
    parameter int     W   = 32,
    parameter int     NIN = 2,
    parameter rt_op_e OP  = RT_XOR
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [NIN-1:0][W-1:0]   d,
    output logic [W-1:0]            q
);

    logic [W-1:0] acc;

    generate
        if (NIN == 1) begin : g_delay
            // Lone leftover operand: same register depth as a real node.
            assign acc = d[0];
        end else begin : g_combine
            always_comb begin
                acc = d[0];
                for (int i = 1; i < NIN; i++) begin
                    unique case (OP)
                        RT_AND:  acc = acc & d[i];
                        RT_OR:   acc = acc | d[i];
                        default: acc = acc ^ d[i];
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= acc;
        end
    end

endmodule

// File: rtl/redtree_level.sv
module redtree_level
    import redtree_pkg::*;
#(
    parameter int     W      = 32,
    parameter int     IN_CNT = 9,
    parameter int     K      = 3,
    parameter rt_op_e OP     = RT_XOR,
    localparam int    OUT_CNT = (IN_CNT + K - 1) / K
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [IN_CNT-1:0][W-1:0]    din,
    output logic [OUT_CNT-1:0][W-1:0]   dout
);

    generate
        for (genvar g = 0; g < OUT_CNT; g++) begin : g_node
            localparam int LO  = g * K;
            localparam int NIN = ((IN_CNT - LO) < K) ? (IN_CNT - LO) : K;

            redtree_node #(
                .W   (W),
                .NIN (NIN),
                .OP  (OP)
            ) u_node (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .d     (din[LO+NIN-1:LO]),
                .q     (dout[g])
            );
        end
    endgenerate

endmodule

// File: rtl/redtree_vpipe.sv
module redtree_vpipe #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    output logic [DEPTH-1:0] lvl_en,
    output logic             vout
);

    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= vin;
            for (int i = 1; i < DEPTH; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    // Level l loads when the flag entering it is set.
    always_comb begin
        lvl_en[0] = vin;
        for (int i = 1; i < DEPTH; i++) begin
            lvl_en[i] = sr[i-1];
        end
    end

    assign vout = sr[DEPTH-1];

endmodule

// File: rtl/redtree_top.sv
module redtree_top
    import redtree_pkg::*;
#(
    parameter int     N  = 25,
    parameter int     K  = 5,
    parameter int     W  = 32,
    parameter rt_op_e OP = RT_XOR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [N*W-1:0]   in_data,
    output logic             out_valid,
    output logic [W-1:0]     out_data
);

    localparam int LEVELS = rt_levels(N, K);

    logic [LEVELS-1:0] lvl_en;

    redtree_vpipe #(
        .DEPTH (LEVELS)
    ) u_vpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .vin    (in_valid),
        .lvl_en (lvl_en),
        .vout   (out_valid)
    );

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int IC = rt_count(N, K, l);
            localparam int OC = rt_count(N, K, l + 1);

            logic [OC-1:0][W-1:0] q;

            if (l == 0) begin : g_first
                redtree_level #(
                    .W      (W),
                    .IN_CNT (IC),
                    .K      (K),
                    .OP     (OP)
                ) u_level (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (lvl_en[l]),
                    .din   (in_data),
                    .dout  (q)
                );
            end else begin : g_next
                redtree_level #(
                    .W      (W),
                    .IN_CNT (IC),
                    .K      (K),
                    .OP     (OP)
                ) u_level (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (lvl_en[l]),
                    .din   (g_lvl[l-1].q),
                    .dout  (q)
                );
            end
        end
    endgenerate

    assign out_data = g_lvl[LEVELS-1].q;

endmodule

// File: rtl/redtree_chk.sv
module redtree_chk #(
    parameter int W      = 32,
    parameter int LEVELS = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_data
);

    logic [31:0] since_rst;
    logic [31:0] in_cnt;
    logic [31:0] out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            in_cnt    <= '0;
            out_cnt   <= '0;
        end else begin
            if (since_rst < 32'(LEVELS)) since_rst <= since_rst + 32'd1;
            if (in_valid)  in_cnt  <= in_cnt + 32'd1;
            if (out_valid) out_cnt <= out_cnt + 32'd1;
        end
    end

    p_reset_clears_r6: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 32'(LEVELS)) |-> !out_valid);

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    p_no_phantom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_cnt != out_cnt));

    p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt - out_cnt) <= 32'(LEVELS));

    p_known_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data));

endmodule

bind redtree_top redtree_chk #(
    .W      (W),
    .LEVELS (LEVELS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_redtree_top.sv
`timescale 1ns/1ps
module sim_redtree_top;
    import redtree_pkg::*;

    localparam int N0 = 25, K0 = 5;
    localparam int N1 = 9,  K1 = 2;
    localparam int N2 = 25, K2 = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] opx [25];
    logic [31:0] opa [25];
    logic [N0*32-1:0] bx = '0;
    logic [N2*32-1:0] ba = '0;

    logic o0v, o1v, o2v;
    logic [31:0] o0d, o1d, o2d;

    redtree_top #(.N(N0), .K(K0), .W(32), .OP(RT_XOR)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(bx),
        .out_valid(o0v), .out_data(o0d));

    redtree_top #(.N(N1), .K(K1), .W(32), .OP(RT_OR)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(bx[N1*32-1:0]),
        .out_valid(o1v), .out_data(o1d));

    redtree_top #(.N(N2), .K(K2), .W(32), .OP(RT_AND)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(ba),
        .out_valid(o2v), .out_data(o2d));

    int nchk = 0;
    int nerr = 0;
    bit check_en = 1'b0;

    function automatic int tb_lat(input int n, input int k);
        int p = 1;
        int l = 0;
        while (p < n) begin
            p = p * k;
            l++;
        end
        return l;
    endfunction

    function automatic logic [31:0] fold(input int op, input int n, input logic [31:0] v [25]);
        logic [31:0] r = v[0];
        for (int i = 1; i < n; i++) begin
            if (op == 0) r = r & v[i];
            else if (op == 1) r = r | v[i];
            else r = r ^ v[i];
        end
        return r;
    endfunction

    int lat [3];
    logic        mv [3][8];
    logic [31:0] md [3][8];
    logic [31:0] hold [3];
    string tagd [3] = '{"R3", "R2 R8", "R1 R9"};

    initial begin
        lat[0] = tb_lat(N0, K0);
        lat[1] = tb_lat(N1, K1);
        lat[2] = tb_lat(N2, K2);
        for (int i = 0; i < 25; i++) begin
            opx[i] = '0;
            opa[i] = '0;
        end
    end

    // Behavioural reference: queue of expected results per build.
    always @(posedge clk) begin
        for (int j = 0; j < 3; j++) begin
            if (!rst_n) begin
                for (int i = 0; i < 8; i++) begin
                    mv[j][i] = 1'b0;
                    md[j][i] = '0;
                end
                hold[j] = '0;
            end else begin
                for (int i = 7; i > 0; i--) begin
                    mv[j][i] = mv[j][i-1];
                    md[j][i] = md[j][i-1];
                end
                mv[j][0] = in_valid;
                if (j == 0) md[j][0] = fold(2, N0, opx);
                else if (j == 1) md[j][0] = fold(1, N1, opx);
                else md[j][0] = fold(0, N2, opa);
                if (mv[j][lat[j]-1]) hold[j] = md[j][lat[j]-1];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at %0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (check_en) begin
            for (int j = 0; j < 3; j++) begin
                logic ov;
                logic [31:0] od;
                logic ev;
                ov = (j == 0) ? o0v : (j == 1) ? o1v : o2v;
                od = (j == 0) ? o0d : (j == 1) ? o1d : o2d;
                ev = rst_n ? mv[j][lat[j]-1] : 1'b0;
                chk(ov === ev, "R4 R5 R6 valid", {31'd0, ov}, {31'd0, ev});
                chk(od === hold[j], ev ? tagd[j] : "R7 hold", od, hold[j]);
            end
        end
    end

    task automatic build();
        for (int i = 0; i < 25; i++) begin
            bx[i*32 +: 32] = opx[i];
            ba[i*32 +: 32] = opa[i];
        end
    endtask

    // mode: 0 random, 1 all ones, 2 all zeros, 3 lone bit in the leftover operands
    task automatic step(input bit v, input int mode);
        @(posedge clk);
        #2;
        in_valid = v;
        for (int i = 0; i < 25; i++) begin
            case (mode)
                0: begin
                    opx[i] = $urandom;
                    opa[i] = ~($urandom & $urandom & $urandom);
                end
                1: begin
                    opx[i] = '1;
                    opa[i] = '1;
                end
                2: begin
                    opx[i] = '0;
                    opa[i] = '0;
                end
                default: begin
                    opx[i] = ((i == 24) || (i == 8)) ? 32'h0000_0020 : 32'h0;
                    opa[i] = (i == 24) ? ~32'h0000_0020 : 32'hFFFF_FFFF;
                end
            endcase
        end
        build();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        @(posedge clk);
        check_en = 1'b1;
        // R6: outputs held cleared during reset, then quiet after release
        repeat (4) step(1'b1, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        in_valid = 1'b0;
        repeat (6) step(1'b0, 0);
        // R5: back-to-back valid sets
        repeat (40) step(1'b1, 0);
        // R7: gaps with random operands while idle
        for (int c = 0; c < 60; c++) step(1'($urandom_range(0, 1)), 0);
        // corner vectors
        step(1'b1, 1);
        step(1'b1, 2);
        step(1'b1, 3);   // R9 and R8: leftover operand reaches result
        step(1'b0, 1);
        step(1'b0, 0);
        step(1'b1, 3);
        step(1'b1, 1);
        repeat (12) step(1'b0, 0);
        // R6: reset mid-stream clears valid
        step(1'b1, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        repeat (3) step(1'b1, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (10) step(1'b1, 0);
        repeat (10) step(1'b0, 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule